// File: doc/BRIEF.md
# Multi-Shot Trigger Capture Controller

This block sequences the capture of several trigger-aligned shots into an on-chip sample buffer shared by a four-channel sampling front end. The buffer is split into equal segments, one per shot. For each shot the controller first fills a programmed number of samples taken before the trigger, then waits for a trigger, then stores a programmed number of samples that starts with the trigger sample itself. Between shots a programmable dead time stops the capture and discards triggers, which bounds how often shots can be taken. After the last shot it raises a done flag.

The buffer write port is driven directly: a write enable and an address made of the segment index (upper bits) and a sample offset inside the segment (lower bits). While samples are taken before the trigger, the offset wraps around inside the segment, so the segment always holds the most recent samples. When a trigger is taken, its buffer address is registered and announced by a one-cycle strobe. Three sticky error flags report a bad configuration, a restart over data the host has not read, and a host read attempted during a capture. Each flag can drive the interrupt output.

Top module: `shot_capture_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `wr_en`, `trig_stb`, `irq` are 0 and `err_flags` is 0.
- R2: After an accepted start, the first `cfg_pre` valid samples are written at offsets 0, 1, 2, … of segment 0 (address = segment × 2^OFF_W + offset). A trigger during this phase is ignored and gives no `trig_stb`.
- R3: Once the pre-trigger count is complete, a cycle with `trig` and `smp_valid` both high is the trigger. Its sample is written, and in the next cycle `trig_stb` is 1 and `trig_pos` holds its write address.
- R4: `cfg_post` includes the trigger sample. Exactly `cfg_post` samples are written from the trigger on, so `cfg_post` = 1 captures the trigger sample alone.
- R5: The write offset advances by one per written sample and wraps modulo 2^OFF_W inside the segment. A shot with `cfg_pre` + `cfg_post` equal to the segment depth is captured in full.
- R6: After the last sample of a shot, the shot counter is decremented and a dead time of `cfg_hold` + 1 cycles follows. During it nothing is written and triggers are ignored. The next shot then starts in the next segment at offset 0.
- R7: After `cfg_shots` shots and their dead time, `done` = 1 and `busy` = 0. `done` stays set until a start or a stop.
- R8: `stop` blocks any write in its own cycle and returns the block to idle (`busy` = 0, `done` = 0) in the next cycle, from any state.
- R9: A start is rejected if `cfg_shots` is 0 or larger than 2^SEG_W, if `cfg_post` is 0, or if `cfg_pre` + `cfg_post` exceeds 2^OFF_W. A rejected start leaves the block idle and sets `err_flags[2]`.
- R10: A start that is accepted after a capture has reached done, with no `host_rd_done` since then, sets `err_flags[0]`. After `host_rd_done` a start does not set it.
- R11: `host_rd` while `busy` is 1 sets `err_flags[1]`.
- R12: Each error flag stays set until a 1 is written to its bit of `err_clr`. If a flag is set and cleared in the same cycle, the set wins. `irq` is 1 while any flag is set whose bit in `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a multi-shot capture |
| stop | input | 1 | Abort and return to idle |
| smp_valid | input | 1 | A new sample set is present this cycle |
| trig | input | 1 | Trigger, qualified by `smp_valid` |
| cfg_shots | input | SEG_W+1 | Number of shots |
| cfg_pre | input | OFF_W+1 | Samples before the trigger |
| cfg_post | input | OFF_W+1 | Samples from the trigger on, trigger included |
| cfg_hold | input | HOLD_W | Dead time after each shot, in cycles minus one |
| host_rd | input | 1 | Host read attempt |
| host_rd_done | input | 1 | Host has finished reading the buffer |
| err_clr | input | 3 | Write-one-to-clear for the error flags |
| irq_en | input | 3 | Interrupt enable for each error flag |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | OFF_W+SEG_W | Buffer write address {segment, offset} |
| trig_stb | output | 1 | `trig_pos` was updated |
| trig_pos | output | OFF_W+SEG_W | Buffer address of the last trigger sample |
| busy | output | 1 | A capture is in progress |
| done | output | 1 | All shots captured |
| err_flags | output | 3 | Sticky errors: [0] overwrite, [1] read while busy, [2] configuration |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a host read during a capture sets the read-while-busy flag, and a write-one-to-clear to that same flag. The bench drives `host_rd` and `err_clr[1]` together during a capture and expects the flag to be set in the next cycle. It then expects `irq` to follow the enable, and a later clear on its own to remove the flag. A second overlap is a trigger that arrives during the dead time or during the pre-trigger fill. These triggers are driven together with valid samples, and the bench expects no write, no strobe and unchanged addresses for the following shot.

// File: rtl/shot_capture_pkg.sv
package shot_capture_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT,
        ST_POST,
        ST_DECR,
        ST_DONE
    } cap_state_e;

    localparam int ERR_N = 3;

    // Bit order matches err_flags: [2] config, [1] read while busy, [0] overwrite
    typedef struct packed {
        logic cfg_bad;
        logic rd_busy;
        logic overwrite;
    } err_evt_t;

    function automatic logic cfg_valid(input int unsigned shots,
                                       input int unsigned pre,
                                       input int unsigned post,
                                       input int unsigned nseg,
                                       input int unsigned depth);
        return (shots != 0) && (shots <= nseg) && (post != 0) && (pre + post <= depth);
    endfunction

endpackage

// File: rtl/shot_capture_fsm.sv
module shot_capture_fsm
    import shot_capture_pkg::*;
#(
    parameter int OFF_W  = 4,
    parameter int SEG_W  = 2,
    parameter int HOLD_W = 8,
    localparam int ADDR_W = OFF_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              smp_valid,
    input  logic              trig,
    input  logic [SEG_W:0]    cfg_shots,
    input  logic [OFF_W:0]    cfg_pre,
    input  logic [OFF_W:0]    cfg_post,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              host_rd,
    input  logic              host_rd_done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              trig_stb,
    output logic [ADDR_W-1:0] trig_pos,
    output logic              busy,
    output logic              done,
    output err_evt_t          evt,
    output cap_state_e        state_o
);

    localparam int DEPTH = 1 << OFF_W;
    localparam int NSEG  = 1 << SEG_W;

    cap_state_e        state;
    logic [SEG_W-1:0]  seg;
    logic [OFF_W-1:0]  off;
    logic [OFF_W:0]    cnt;
    logic [SEG_W:0]    shots_left;
    logic [SEG_W:0]    shots_nxt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              unread;
    logic              cfg_good;
    logic              start_go;
    logic              capturing;
    logic              trig_hit;
    cap_state_e        first_state;

    assign cfg_good   = cfg_valid(int'(cfg_shots), int'(cfg_pre), int'(cfg_post), NSEG, DEPTH);
    assign start_go   = start && !stop && (state == ST_IDLE || state == ST_DONE);
    assign capturing  = (state == ST_PRE) || (state == ST_WAIT) || (state == ST_POST);
    assign wr_en      = capturing && smp_valid && !stop;
    assign wr_addr    = {seg, off};
    assign trig_hit   = (state == ST_WAIT) && smp_valid && trig && !stop;
    assign busy       = (state != ST_IDLE) && (state != ST_DONE);
    assign done       = (state == ST_DONE);
    assign state_o    = state;
    assign first_state = (cfg_pre == '0) ? ST_WAIT : ST_PRE;
    // the decrement takes effect in the first dead-time cycle
    assign shots_nxt  = (hold_cnt == '0) ? shots_left - 1'b1 : shots_left;

    assign evt.cfg_bad   = start_go && !cfg_good;
    assign evt.overwrite = start_go && cfg_good && unread;
    assign evt.rd_busy   = host_rd && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            seg        <= '0;
            off        <= '0;
            cnt        <= '0;
            shots_left <= '0;
            hold_cnt   <= '0;
            trig_stb   <= 1'b0;
            trig_pos   <= '0;
            unread     <= 1'b0;
        end else begin
            trig_stb <= trig_hit;
            if (host_rd_done) begin
                unread <= 1'b0;
            end
            if (stop) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_DONE: begin
                        if (start_go && cfg_good) begin
                            state      <= first_state;
                            seg        <= '0;
                            off        <= '0;
                            cnt        <= '0;
                            shots_left <= cfg_shots;
                        end
                    end
                    ST_PRE: begin
                        if (smp_valid) begin
                            off <= off + 1'b1;
                            cnt <= cnt + 1'b1;
                            if (cnt + 1'b1 == cfg_pre) begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_WAIT: begin
                        if (smp_valid) begin
                            off <= off + 1'b1;
                            if (trig) begin
                                trig_pos <= {seg, off};
                                cnt      <= 1;
                                hold_cnt <= '0;
                                state    <= (cfg_post == 1) ? ST_DECR : ST_POST;
                            end
                        end
                    end
                    ST_POST: begin
                        if (smp_valid) begin
                            off <= off + 1'b1;
                            cnt <= cnt + 1'b1;
                            if (cnt + 1'b1 == cfg_post) begin
                                hold_cnt <= '0;
                                state    <= ST_DECR;
                            end
                        end
                    end
                    ST_DECR: begin
                        shots_left <= shots_nxt;
                        if (hold_cnt == cfg_hold) begin
                            if (shots_nxt == '0) begin
                                state  <= ST_DONE;
                                unread <= 1'b1;
                            end else begin
                                seg   <= seg + 1'b1;
                                off   <= '0;
                                cnt   <= '0;
                                state <= first_state;
                            end
                        end else begin
                            hold_cnt <= hold_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/shot_capture_errs.sv
module shot_capture_errs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flags,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (evt[i]) begin
                bit_q <= 1'b1;
            end else if (clr[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign flags[i] = bit_q;
    end

    assign irq = |(flags & irq_en);

endmodule

// File: rtl/shot_capture_ctrl.sv
module shot_capture_ctrl
    import shot_capture_pkg::*;
#(
    parameter int OFF_W  = 4,
    parameter int SEG_W  = 2,
    parameter int HOLD_W = 8,
    localparam int ADDR_W = OFF_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              smp_valid,
    input  logic              trig,
    input  logic [SEG_W:0]    cfg_shots,
    input  logic [OFF_W:0]    cfg_pre,
    input  logic [OFF_W:0]    cfg_post,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              host_rd,
    input  logic              host_rd_done,
    input  logic [2:0]        err_clr,
    input  logic [2:0]        irq_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              trig_stb,
    output logic [ADDR_W-1:0] trig_pos,
    output logic              busy,
    output logic              done,
    output logic [2:0]        err_flags,
    output logic              irq
);

    err_evt_t   evt;
    cap_state_e cap_state;

    shot_capture_fsm #(
        .OFF_W (OFF_W),
        .SEG_W (SEG_W),
        .HOLD_W(HOLD_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .stop        (stop),
        .smp_valid   (smp_valid),
        .trig        (trig),
        .cfg_shots   (cfg_shots),
        .cfg_pre     (cfg_pre),
        .cfg_post    (cfg_post),
        .cfg_hold    (cfg_hold),
        .host_rd     (host_rd),
        .host_rd_done(host_rd_done),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .trig_stb    (trig_stb),
        .trig_pos    (trig_pos),
        .busy        (busy),
        .done        (done),
        .evt         (evt),
        .state_o     (cap_state)
    );

    shot_capture_errs #(
        .N(ERR_N)
    ) u_errs (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .clr   (err_clr),
        .irq_en(irq_en),
        .flags (err_flags),
        .irq   (irq)
    );

endmodule

// File: rtl/shot_capture_chk.sv
module shot_capture_chk
    import shot_capture_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stop,
    input logic       wr_en,
    input logic       trig_stb,
    input logic       busy,
    input logic       done,
    input logic [2:0] err_flags,
    input logic [2:0] err_clr,
    input cap_state_e cap_state
);

    // R8: a stop leaves the block idle one cycle later
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !done));

    // R6: the dead time never writes the buffer
    a_r6_no_write_in_hold: assert property (@(posedge clk) disable iff (rst)
        (cap_state == ST_DECR) |-> !wr_en);

    // R7: done and busy never overlap
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: a trigger strobe always follows a written trigger sample
    a_r3_strobe_after_write: assert property (@(posedge clk) disable iff (rst)
        trig_stb |-> $past(wr_en));

    // R12: a flag only drops where a clear was written
    a_r12_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(err_flags) & ~$past(err_clr)) & ~err_flags) == 3'b000));

    // R9: a configuration error appears with the block idle
    a_r9_cfg_reject_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flags[2]) |-> !busy);

endmodule

bind shot_capture_ctrl shot_capture_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .stop     (stop),
    .wr_en    (wr_en),
    .trig_stb (trig_stb),
    .busy     (busy),
    .done     (done),
    .err_flags(err_flags),
    .err_clr  (err_clr),
    .cap_state(cap_state)
);

// File: tb/shot_capture_ctrl_bench.sv
module shot_capture_ctrl_bench;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, stop = 1'b0, smp_valid = 1'b0, trig = 1'b0;
    logic [2:0] cfg_shots = '0;
    logic [4:0] cfg_pre = '0, cfg_post = '0;
    logic [7:0] cfg_hold = '0;
    logic       host_rd = 1'b0, host_rd_done = 1'b0;
    logic [2:0] err_clr = '0, irq_en = '0;
    logic       wr_en, trig_stb, busy, done, irq;
    logic [5:0] wr_addr, trig_pos;
    logic [2:0] err_flags;

    int n_chk = 0;
    int n_fail = 0;
    int off = 0;

    always #5 clk = ~clk;

    shot_capture_ctrl u_shot_capture_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .smp_valid(smp_valid), .trig(trig),
        .cfg_shots(cfg_shots), .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_hold(cfg_hold),
        .host_rd(host_rd), .host_rd_done(host_rd_done),
        .err_clr(err_clr), .irq_en(irq_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .trig_stb(trig_stb), .trig_pos(trig_pos),
        .busy(busy), .done(done), .err_flags(err_flags), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives one cycle from posedge+2, returns comb outputs seen at posedge+6
    task automatic tick(input logic v, input logic t, output logic we, output logic [5:0] wa);
        smp_valid = v;
        trig = t;
        #4;
        we = wr_en;
        wa = wr_addr;
        @(posedge clk);
        #2;
        smp_valid = 1'b0;
        trig = 1'b0;
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        idle_cycle();
        start = 1'b0;
    endtask

    task automatic set_cfg(input int s, input int p, input int q, input int h);
        cfg_shots = 3'(s);
        cfg_pre = 5'(p);
        cfg_post = 5'(q);
        cfg_hold = 8'(h);
    endtask

    task automatic clean();
        stop = 1'b1;
        host_rd_done = 1'b1;
        err_clr = 3'b111;
        idle_cycle();
        stop = 1'b0;
        host_rd_done = 1'b0;
        err_clr = 3'b000;
        off = 0;
    endtask

    task automatic do_shot(input int seg, input int pre, input int nwait, input int post, input bit trig_in_pre);
        logic we;
        logic [5:0] wa;
        int exp;
        for (int i = 0; i < pre; i++) begin
            tick(1'b1, trig_in_pre, we, wa);
            chk("R2", "pre write enable", we, 1);
            chk("R2", "pre address", wa, seg * DEPTH + off);
            chk("R2", "pre trigger ignored", trig_stb, 0);
            off = (off + 1) % DEPTH;
        end
        for (int i = 0; i < nwait; i++) begin
            tick(1'b1, 1'b0, we, wa);
            chk("R5", "waiting address", wa, seg * DEPTH + off);
            off = (off + 1) % DEPTH;
        end
        exp = seg * DEPTH + off;
        tick(1'b1, 1'b1, we, wa);
        chk("R3", "trigger write", we, 1);
        chk("R3", "trigger address", wa, exp);
        chk("R3", "trigger strobe", trig_stb, 1);
        chk("R3", "trigger position", trig_pos, exp);
        off = (off + 1) % DEPTH;
        for (int i = 0; i < post - 1; i++) begin
            tick(1'b1, 1'b0, we, wa);
            chk("R4", "post write enable", we, 1);
            chk("R5", "post address", wa, seg * DEPTH + off);
            off = (off + 1) % DEPTH;
        end
    endtask

    task automatic do_hold(input int h);
        logic we;
        logic [5:0] wa;
        for (int i = 0; i <= h; i++) begin
            tick(1'b1, 1'b1, we, wa);
            chk("R6", "no write in dead time", we, 0);
            chk("R6", "trigger ignored in dead time", trig_stb, 0);
        end
        off = 0;
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "wr_en", wr_en, 0);
        chk("R1", "trig_stb", trig_stb, 0);
        chk("R1", "err_flags", err_flags, 0);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_multi();
        set_cfg(2, 3, 2, 2);
        off = 0;
        pulse_start();
        chk("R2", "busy after start", busy, 1);
        do_shot(0, 3, 1, 2, 1'b1);
        do_hold(2);
        chk("R6", "busy for next shot", busy, 1);
        do_shot(1, 3, 0, 2, 1'b0);
        do_hold(2);
        chk("R7", "done", done, 1);
        chk("R7", "not busy", busy, 0);
        repeat (3) idle_cycle();
        chk("R7", "done held", done, 1);
    endtask

    task automatic t_overwrite();
        pulse_start();
        chk("R10", "overwrite flag", err_flags[0], 1);
        stop = 1'b1;
        #4;
        chk("R8", "no write during stop", wr_en, 0);
        idle_cycle();
        stop = 1'b0;
        chk("R8", "idle after stop", busy, 0);
        clean();
        chk("R12", "flags cleared", err_flags, 0);
        pulse_start();
        chk("R10", "no overwrite after read", err_flags[0], 0);
        clean();
    endtask

    task automatic t_full_depth();
        set_cfg(1, 10, 6, 0);
        off = 0;
        pulse_start();
        do_shot(0, 10, 5, 6, 1'b0);
        chk("R5", "wrapped offset after full shot", off, 5);
        do_hold(0);
        chk("R7", "done after full depth", done, 1);
        clean();
    endtask

    task automatic t_post_one();
        logic we;
        logic [5:0] wa;
        set_cfg(1, 0, 1, 1);
        off = 0;
        pulse_start();
        do_shot(0, 0, 2, 1, 1'b0);
        tick(1'b1, 1'b0, we, wa);
        chk("R4", "only the trigger sample written", we, 0);
        tick(1'b1, 1'b0, we, wa);
        chk("R4", "done after single sample", done, 1);
        clean();
    endtask

    task automatic t_cfg_err();
        set_cfg(1, 10, 7, 0);
        pulse_start();
        chk("R9", "pre+post too large flag", err_flags[2], 1);
        chk("R9", "stays idle", busy, 0);
        clean();
        set_cfg(5, 1, 1, 0);
        pulse_start();
        chk("R9", "too many shots flag", err_flags[2], 1);
        chk("R9", "stays idle (shots)", busy, 0);
        clean();
        set_cfg(1, 2, 0, 0);
        pulse_start();
        chk("R9", "zero post flag", err_flags[2], 1);
        clean();
    endtask

    task automatic t_read_busy();
        set_cfg(1, 3, 2, 0);
        pulse_start();
        irq_en = 3'b010;
        host_rd = 1'b1;
        err_clr = 3'b010;
        idle_cycle();
        host_rd = 1'b0;
        err_clr = 3'b000;
        chk("R11", "read while busy flag", err_flags[1], 1);
        chk("R12", "irq enabled", irq, 1);
        irq_en = 3'b000;
        #1;
        chk("R12", "irq masked", irq, 0);
        err_clr = 3'b010;
        idle_cycle();
        err_clr = 3'b000;
        chk("R12", "flag cleared by write one", err_flags[1], 0);
        clean();
        host_rd = 1'b1;
        idle_cycle();
        host_rd = 1'b0;
        chk("R11", "read while idle no flag", err_flags[1], 0);
    endtask

    task automatic t_stop();
        logic we;
        logic [5:0] wa;
        set_cfg(2, 3, 4, 0);
        off = 0;
        pulse_start();
        do_shot(0, 3, 0, 2, 1'b0);
        stop = 1'b1;
        smp_valid = 1'b1;
        #4;
        chk("R8", "write blocked by stop", wr_en, 0);
        idle_cycle();
        stop = 1'b0;
        smp_valid = 1'b0;
        chk("R8", "idle after stop in post", busy, 0);
        tick(1'b1, 1'b1, we, wa);
        chk("R8", "no write after stop", we, 0);
        clean();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        t_reset();
        t_multi();
        t_overwrite();
        t_full_depth();
        t_post_one();
        t_cfg_err();
        t_read_busy();
        t_stop();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule